// File: doc/BRIEF.md
# FIFO Interrupt Status Aggregator

This block gathers interrupt events from 32 FIFO channels. Each channel has a transmit direction and a receive direction. The channels are split into 8 groups of 4. Every group keeps an 8-bit sticky status register. A single 8-bit summary register tells a host which groups hold anything pending. Event inputs are one-cycle pulses (or levels) per FIFO and direction. Any asserted input is latched into its group register and stays there until that register is read.

A host reads through a synchronous port. It presents an address together with a one-cycle read strobe, and gets the data and a valid flag in the next cycle. A read of a group register returns the register's contents and empties it in the same clock edge. A read of the summary register disturbs nothing. A single interrupt line stays high while any status bit is set.

The read port is a small state machine that records which kind of access it served last. Its states are:
- RD_IDLE: no response this cycle.
- RD_SUMMARY: the summary register was read.
- RD_GROUP: a group register was read.
- RD_UNMAPPED: an address outside the map was read.

From any state, a strobe moves the machine to the state matching the decoded address. A cycle without a strobe returns it to RD_IDLE.

Top module: `intr_fifo_aggregator`

## Requirements
- R1: After a synchronous active-high reset, every group register, the summary, `irq` and `rd_valid` are 0.
- R2: A transmit event of FIFO f sets bit 2*(f mod 4) of group register f/4. A receive event of FIFO f sets bit 2*(f mod 4)+1 of that register. Group register g sits at address 0x11+g, for g = 0..7.
- R3: A latched status bit stays set, however long, until its group register is read.
- R4: The summary register at address 0x10 has bit g set exactly when group register g is nonzero. Its bits rise again as soon as a new event is latched after a clear.
- R5: Reading the summary register leaves every group register and summary bit unchanged.
- R6: A read of a group register returns its contents before the read and clears all 8 of its bits. The matching summary bit drops unless a new event arrives.
- R7: An event that arrives in the same cycle as the clearing read of its group is kept set after the read. It is not part of the returned value.
- R8: `irq` is high exactly while at least one summary bit is set.
- R9: A read of any address other than 0x10..0x18 returns 0 and changes no status bit.
- R10: A strobe in cycle t gives `rd_valid`=1 and the read data in cycle t+1 only. Without a strobe, `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_evt | input | 32 | Transmit interrupt event, one bit per FIFO |
| rx_evt | input | 32 | Receive interrupt event, one bit per FIFO |
| rd_stb | input | 1 | One-cycle read strobe |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| rd_valid | output | 1 | High in the cycle that carries read data |
| irq | output | 1 | High while any status bit is pending |

## Verification
The assertions assume that `rst` is held for at least one clock before any read. They also assume that the strobe and address are stable around each rising edge. The bench drives every input on the falling edge, opens with a reset, and samples results on the next falling edge, so both assumptions hold. The assertions place no limit on how events coincide with reads. The bench deliberately makes an event land on the same edge as the clearing read of its group.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

    typedef enum logic [1:0] {
        RD_IDLE     = 2'd0,
        RD_SUMMARY  = 2'd1,
        RD_GROUP    = 2'd2,
        RD_UNMAPPED = 2'd3
    } rd_state_e;

endpackage

// File: rtl/intr_group_reg.sv
module intr_group_reg #(
    parameter int FIFOS = 4,
    localparam int W    = 2 * FIFOS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [FIFOS-1:0] tx_evt,
    input  logic [FIFOS-1:0] rx_evt,
    input  logic             clr,
    output logic [W-1:0]     stat,
    output logic             pending
);

    logic [W-1:0] evt;

    // Interleave directions: even bit transmit, odd bit receive
    for (genvar k = 0; k < FIFOS; k++) begin : g_map
        assign evt[2*k]   = tx_evt[k];
        assign evt[2*k+1] = rx_evt[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (clr) begin
            stat <= evt;
        end else begin
            stat <= stat | evt;
        end
    end

    assign pending = |stat;

    p_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((stat & $past(stat)) == $past(stat)));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && evt == '0) |=> (stat == '0));

    p_keep_same_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (clr && evt != '0) |=> (stat == $past(evt)));

endmodule

// File: rtl/intr_read_port.sv
module intr_read_port
    import intr_agg_pkg::*;
#(
    parameter int              NUM_GROUPS = 8,
    parameter int              DATA_W     = 8,
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] SUM_ADDR = 8'h10,
    parameter logic [ADDR_W-1:0] GRP_BASE = 8'h11
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         rd_stb,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NUM_GROUPS*DATA_W-1:0] grp_stat,
    input  logic [NUM_GROUPS-1:0]        summary,
    output logic [NUM_GROUPS-1:0]        clr_vec,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         rd_valid
);

    rd_state_e         state_q, state_d;
    logic [DATA_W-1:0] sum_word;
    logic [DATA_W-1:0] grp_word;
    logic [DATA_W-1:0] data_d;
    logic              hit_grp;

    // Summary zero-extended (or trimmed) to the data width
    for (genvar i = 0; i < DATA_W; i++) begin : g_sum
        if (i < NUM_GROUPS) begin : g_bit
            assign sum_word[i] = summary[i];
        end else begin : g_pad
            assign sum_word[i] = 1'b0;
        end
    end

    // Group address decode and data select
    always_comb begin
        hit_grp  = 1'b0;
        grp_word = '0;
        clr_vec  = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (rd_addr == GRP_BASE + ADDR_W'(g)) begin
                hit_grp    = 1'b1;
                grp_word   = grp_stat[g*DATA_W +: DATA_W];
                clr_vec[g] = rd_stb;
            end
        end
    end

    // Next state and registered data
    always_comb begin
        state_d = RD_IDLE;
        data_d  = '0;
        if (rd_stb) begin
            unique case (1'b1)
                (rd_addr == SUM_ADDR): begin
                    state_d = RD_SUMMARY;
                    data_d  = sum_word;
                end
                hit_grp: begin
                    state_d = RD_GROUP;
                    data_d  = grp_word;
                end
                default: begin
                    state_d = RD_UNMAPPED;
                    data_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RD_IDLE;
            rd_data <= '0;
        end else begin
            state_q <= state_d;
            rd_data <= data_d;
        end
    end

    always_comb begin
        unique case (state_q)
            RD_IDLE:     rd_valid = 1'b0;
            RD_SUMMARY:  rd_valid = 1'b1;
            RD_GROUP:    rd_valid = 1'b1;
            RD_UNMAPPED: rd_valid = 1'b1;
            default:     rd_valid = 1'b0;
        endcase
    end

    p_valid_after_stb_r10: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> rd_valid);

    p_no_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> !rd_valid);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr != SUM_ADDR && !hit_grp) |=> (rd_data == '0));

    p_clr_onehot_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_vec));

endmodule

// File: rtl/intr_fifo_aggregator.sv
module intr_fifo_aggregator #(
    parameter int              NUM_GROUPS      = 8,
    parameter int              FIFOS_PER_GROUP = 4,
    parameter int              ADDR_W          = 8,
    parameter logic [ADDR_W-1:0] SUMMARY_ADDR  = 8'h10,
    parameter logic [ADDR_W-1:0] GROUP_BASE    = 8'h11,
    localparam int             NUM_FIFOS       = NUM_GROUPS * FIFOS_PER_GROUP,
    localparam int             DATA_W          = 2 * FIFOS_PER_GROUP
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_FIFOS-1:0] tx_evt,
    input  logic [NUM_FIFOS-1:0] rx_evt,
    input  logic                 rd_stb,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic                 rd_valid,
    output logic                 irq
);

    logic [NUM_GROUPS*DATA_W-1:0] grp_stat;
    logic [NUM_GROUPS-1:0]        summary;
    logic [NUM_GROUPS-1:0]        clr_vec;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        intr_group_reg #(
            .FIFOS (FIFOS_PER_GROUP)
        ) grp_i (
            .clk     (clk),
            .rst     (rst),
            .tx_evt  (tx_evt[g*FIFOS_PER_GROUP +: FIFOS_PER_GROUP]),
            .rx_evt  (rx_evt[g*FIFOS_PER_GROUP +: FIFOS_PER_GROUP]),
            .clr     (clr_vec[g]),
            .stat    (grp_stat[g*DATA_W +: DATA_W]),
            .pending (summary[g])
        );
    end

    intr_read_port #(
        .NUM_GROUPS (NUM_GROUPS),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .SUM_ADDR   (SUMMARY_ADDR),
        .GRP_BASE   (GROUP_BASE)
    ) rdp_i (
        .clk      (clk),
        .rst      (rst),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr),
        .grp_stat (grp_stat),
        .summary  (summary),
        .clr_vec  (clr_vec),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    assign irq = |summary;

    p_summary_read_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && rd_addr == SUMMARY_ADDR)
            |=> ((grp_stat & $past(grp_stat)) == $past(grp_stat)));

    p_irq_after_event_r8: assert property (@(posedge clk) disable iff (rst)
        ((tx_evt | rx_evt) != '0) |=> irq);

endmodule

// File: tb/intr_fifo_aggregator_tb.sv
module intr_fifo_aggregator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SUM_A = 8'h10;
    localparam logic [7:0] GRP_A = 8'h11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_evt = '0;
    logic [31:0] rx_evt = '0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] exp_g [8];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intr_fifo_aggregator dut_i (
        .clk(clk), .rst(rst), .tx_evt(tx_evt), .rx_evt(rx_evt),
        .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_sum();
        logic [7:0] s;
        for (int g = 0; g < 8; g++) s[g] = (exp_g[g] != 8'h00);
        return s;
    endfunction

    task automatic do_read(input logic [7:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        rd_stb  = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_stb  = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic pulse(input int f, input bit is_rx);
        @(negedge clk);
        if (is_rx) rx_evt[f] = 1'b1; else tx_evt[f] = 1'b1;
        @(negedge clk);
        tx_evt = '0;
        rx_evt = '0;
        if (is_rx) exp_g[f/4][2*(f%4)+1] = 1'b1;
        else       exp_g[f/4][2*(f%4)]   = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic v;
        check("R1 rd_valid", 32'(rd_valid), 0);
        check("R1 irq", 32'(irq), 0);
        for (int g = 0; g < 8; g++) begin
            do_read(GRP_A + 8'(g), d, v);
            check("R1 group", 32'(d), 0);
        end
        do_read(SUM_A, d, v);
        check("R1 summary", 32'(d), 0);
    endtask

    task automatic t_mapping();
        logic [7:0] d; logic v;
        pulse(0, 0);
        pulse(5, 1);
        pulse(31, 0);
        pulse(31, 1);
        pulse(14, 1);
        do_read(SUM_A, d, v);
        check("R4 summary", 32'(d), 32'(exp_sum()));
        do_read(GRP_A + 8'd0, d, v);
        check("R2 fifo0 tx", 32'(d), 32'h01);
        exp_g[0] = '0;
        do_read(GRP_A + 8'd1, d, v);
        check("R2 fifo5 rx", 32'(d), 32'h08);
        exp_g[1] = '0;
        do_read(GRP_A + 8'd7, d, v);
        check("R2 fifo31 both", 32'(d), 32'hC0);
        exp_g[7] = '0;
        do_read(GRP_A + 8'd3, d, v);
        check("R2 fifo14 rx", 32'(d), 32'h20);
        exp_g[3] = '0;
        do_read(SUM_A, d, v);
        check("R6 summary cleared", 32'(d), 0);
        check("R8 irq low", 32'(irq), 0);
    endtask

    task automatic t_sticky_and_summary();
        logic [7:0] d; logic v;
        pulse(9, 0);
        repeat (6) @(negedge clk);
        check("R8 irq high", 32'(irq), 1);
        do_read(SUM_A, d, v);
        check("R4 summary g2", 32'(d), 32'h04);
        do_read(SUM_A, d, v);
        check("R5 summary reread", 32'(d), 32'h04);
        do_read(GRP_A + 8'd2, d, v);
        check("R3 sticky held", 32'(d), 32'h04);
        exp_g[2] = '0;
        do_read(GRP_A + 8'd2, d, v);
        check("R6 cleared", 32'(d), 0);
        check("R8 irq drop", 32'(irq), 0);
        pulse(8, 1);
        do_read(SUM_A, d, v);
        check("R4 rises again", 32'(d), 32'h04);
        do_read(GRP_A + 8'd2, d, v);
        check("R2 fifo8 rx", 32'(d), 32'h02);
        exp_g[2] = '0;
    endtask

    task automatic t_same_cycle();
        logic [7:0] d; logic v;
        pulse(20, 0);
        @(negedge clk);
        rd_stb = 1'b1;
        rd_addr = GRP_A + 8'd5;
        rx_evt[21] = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        rx_evt = '0;
        check("R7 returned old", 32'(rd_data), 32'h01);
        exp_g[5] = 8'h08;
        check("R7 irq held", 32'(irq), 1);
        do_read(GRP_A + 8'd5, d, v);
        check("R7 new kept", 32'(d), 32'h08);
        exp_g[5] = '0;
    endtask

    task automatic t_unmapped();
        logic [7:0] d; logic v;
        pulse(27, 1);
        do_read(8'h00, d, v);
        check("R9 addr00", 32'(d), 0);
        do_read(8'h19, d, v);
        check("R9 addr19", 32'(d), 0);
        check("R9 valid", 32'(v), 1);
        do_read(8'hFF, d, v);
        check("R9 addrFF", 32'(d), 0);
        do_read(SUM_A, d, v);
        check("R9 summary kept", 32'(d), 32'h40);
        do_read(GRP_A + 8'd6, d, v);
        check("R9 group kept", 32'(d), 32'h80);
        exp_g[6] = '0;
    endtask

    task automatic t_timing();
        @(negedge clk);
        check("R10 idle", 32'(rd_valid), 0);
        rd_stb = 1'b1;
        rd_addr = SUM_A;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R10 valid", 32'(rd_valid), 1);
        @(negedge clk);
        check("R10 one cycle", 32'(rd_valid), 0);
    endtask

    initial begin
        for (int g = 0; g < 8; g++) exp_g[g] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mapping();
        t_sticky_and_summary();
        t_same_cycle();
        t_unmapped();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule